// File: doc/BRIEF.md
# Multicast Copy Placement Allocator

This block sits beside the input stage of an on-chip network router and handles multicast flits without any dedicated replication storage. When a flit arrives with a bitmask of destinations, the allocator breaks the mask into single-destination copies. It writes each copy into an idle virtual-channel buffer that the router already has, on some output-side port other than the one the flit came in on. Each copy is tagged with its own destination index, so route computation and switch allocation can forward it on its own. The copies therefore leave at different times rather than in lockstep.

For each copy, the allocator chooses the least-loaded eligible port, meaning the one with the most free virtual channels. Within that port it takes the lowest free channel. It issues one copy per cycle. When no eligible free channel exists, it raises a stall and keeps the original flit until a channel frees up. While a flit is being expanded, the input is closed.

Top module: `mcast_repl_alloc`

## Requirements
- R1: Out of reset, `in_ready` is 1, `stall` is 0 and no bit of `wr_vc_en` is set.
- R2: A flit is taken only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that point until the last copy has been written. A flit offered while `in_ready` is 0 has no effect. A flit whose mask is all zero is taken and produces no write.
- R3: At most one bit of `wr_vc_en` is set per cycle. Bit `p*N_VC+v` selects channel `v` of port `p`. Every set bit of the accepted mask yields exactly one copy, and the copies come out in ascending destination index.
- R4: A copy is never written to a channel whose `vc_busy` bit (same bit layout as `wr_vc_en`) is 1, or to the channel written in the previous cycle.
- R5: A copy is never written to a channel of the port given on `in_port` when the flit was taken.
- R6: The chosen port is the eligible port with the largest number of free channels. A tie goes to the lowest port index.
- R7: Within the chosen port, the lowest-numbered free channel is written.
- R8: If destinations remain and no eligible port has a free channel, `stall` is 1 and nothing is written. The held flit and its remaining destinations are kept, and placement resumes in the first cycle in which a channel is free.
- R9: Each copy presents the accepted payload on `wr_flit`, its destination index on `wr_dest`, and its target on `wr_port`/`wr_vc`. The first copy appears in the cycle after acceptance.
- R10: `in_ready` returns to 1 in the cycle after the last copy is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Multicast flit offered |
| in_ready | output | 1 | Allocator can take a flit |
| in_port | input | PW | Port the flit arrived on |
| in_mask | input | N_DEST | Destination bitmask |
| in_flit | input | FLIT_W | Flit payload |
| vc_busy | input | N_PORTS*N_VC | Occupied flag per virtual channel, bit p*N_VC+v |
| wr_vc_en | output | N_PORTS*N_VC | One-hot buffer write enable for a copy |
| wr_port | output | PW | Port of the written copy |
| wr_vc | output | VW | Channel of the written copy |
| wr_dest | output | DW | Destination index of the copy |
| wr_flit | output | FLIT_W | Payload of the copy |
| stall | output | 1 | Destinations remain but no eligible channel is free |

## Verification
A corrupted pending mask shows up at the ports within one cycle. It appears as a skipped or repeated `wr_dest`, or as `in_ready` rising too early or too late. A wrong free-count or port choice is visible on the very write it affects, as a different `wr_port` or `wr_vc` from the one the least-loaded rule predicts, or as a write onto a busy channel. A lost held flit during a stall shows up on the first write after a channel frees, as a wrong destination or payload.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_COPY = 1'b1
  } mcr_state_e;
endpackage

// File: rtl/mcr_free_count.sv
module mcr_free_count #(
  parameter int N_VC = 4,
  localparam int CW = $clog2(N_VC + 1),
  localparam int VW = (N_VC > 1) ? $clog2(N_VC) : 1
) (
  input  logic [N_VC-1:0] busy,
  output logic [CW-1:0]   free_cnt,
  output logic [VW-1:0]   low_vc
);
  always_comb begin
    free_cnt = '0;
    low_vc   = '0;
    for (int v = N_VC - 1; v >= 0; v--) begin
      if (!busy[v]) begin
        free_cnt = free_cnt + CW'(1);
        low_vc   = VW'(v);
      end
    end
  end
endmodule

// File: rtl/mcr_port_pick.sv
module mcr_port_pick #(
  parameter int N_PORTS = 5,
  parameter int CW      = 3,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic [N_PORTS*CW-1:0] cnt_flat,
  input  logic [PW-1:0]         excl_port,
  output logic                  found,
  output logic [PW-1:0]         pick_port
);
  logic [CW-1:0] best;

  always_comb begin
    found     = 1'b0;
    pick_port = '0;
    best      = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if ((PW'(p) != excl_port) && (cnt_flat[p*CW +: CW] > best)) begin
        best      = cnt_flat[p*CW +: CW];
        pick_port = PW'(p);
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcr_dest_pick.sv
module mcr_dest_pick #(
  parameter int N_DEST = 8,
  localparam int DW = (N_DEST > 1) ? $clog2(N_DEST) : 1
) (
  input  logic [N_DEST-1:0] mask,
  output logic              any,
  output logic [DW-1:0]     idx,
  output logic [N_DEST-1:0] idx_oh
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    idx_oh = '0;
    for (int d = N_DEST - 1; d >= 0; d--) begin
      if (mask[d]) begin
        any    = 1'b1;
        idx    = DW'(d);
        idx_oh = N_DEST'(1) << d;
      end
    end
  end
endmodule

// File: rtl/mcast_repl_alloc.sv
module mcast_repl_alloc
  import mcr_pkg::*;
#(
  parameter int N_PORTS = 5,
  parameter int N_VC    = 4,
  parameter int N_DEST  = 8,
  parameter int FLIT_W  = 32,
  localparam int PW  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int VW  = (N_VC > 1) ? $clog2(N_VC) : 1,
  localparam int DW  = (N_DEST > 1) ? $clog2(N_DEST) : 1,
  localparam int CW  = $clog2(N_VC + 1),
  localparam int NCH = N_PORTS * N_VC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PW-1:0]     in_port,
  input  logic [N_DEST-1:0] in_mask,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic [NCH-1:0]    vc_busy,
  output logic [NCH-1:0]    wr_vc_en,
  output logic [PW-1:0]     wr_port,
  output logic [VW-1:0]     wr_vc,
  output logic [DW-1:0]     wr_dest,
  output logic [FLIT_W-1:0] wr_flit,
  output logic              stall
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // held state
  mcr_state_e        state_q, state_d;
  logic [N_DEST-1:0] pend_q, pend_d;
  logic [FLIT_W-1:0] flit_q;
  logic [PW-1:0]     port_q;
  logic [NCH-1:0]    last_wr_q;
  logic              accept, load_en;

  // channel occupancy as seen this cycle
  logic [NCH-1:0]     eff_busy;
  logic [N_PORTS*CW-1:0] cnt_flat;
  logic [N_PORTS*VW-1:0] low_flat;

  assign eff_busy = vc_busy | last_wr_q;

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      mcr_free_count #(.N_VC(N_VC)) u_cnt (
        .busy     (eff_busy[p*N_VC +: N_VC]),
        .free_cnt (cnt_flat[p*CW +: CW]),
        .low_vc   (low_flat[p*VW +: VW])
      );
    end
  endgenerate

  logic          port_found;
  logic [PW-1:0] pick_port;

  mcr_port_pick #(.N_PORTS(N_PORTS), .CW(CW)) u_pick (
    .cnt_flat  (cnt_flat),
    .excl_port (port_q),
    .found     (port_found),
    .pick_port (pick_port)
  );

  logic              dest_any;
  logic [DW-1:0]     dest_idx;
  logic [N_DEST-1:0] dest_oh;

  mcr_dest_pick #(.N_DEST(N_DEST)) u_dest (
    .mask   (pend_q),
    .any    (dest_any),
    .idx    (dest_idx),
    .idx_oh (dest_oh)
  );

  logic          do_write;
  logic [VW-1:0] pick_vc;

  assign pick_vc  = low_flat[int'(pick_port)*VW +: VW];
  assign do_write = (state_q == ST_COPY) && dest_any && port_found;
  assign stall    = (state_q == ST_COPY) && dest_any && !port_found;
  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign load_en  = accept;

  always_comb begin
    wr_vc_en = '0;
    if (do_write) wr_vc_en = NCH'(1) << (int'(pick_port) * N_VC + int'(pick_vc));
  end

  assign wr_port = pick_port;
  assign wr_vc   = pick_vc;
  assign wr_dest = dest_idx;
  assign wr_flit = flit_q;

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    if (accept) begin
      pend_d  = in_mask;
      state_d = (in_mask != '0) ? ST_COPY : ST_IDLE;
    end else if (do_write) begin
      pend_d  = pend_q & ~dest_oh;
      state_d = (pend_d != '0) ? ST_COPY : ST_IDLE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_IDLE;
      pend_q    <= '0;
      last_wr_q <= '0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      last_wr_q <= wr_vc_en;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      flit_q <= '0;
      port_q <= '0;
    end else if (load_en) begin
      flit_q <= in_flit;
      port_q <= in_port;
    end
  end

  // assertions
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(wr_vc_en));

  a_r4_no_busy_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_vc_en != '0) |-> ((wr_vc_en & vc_busy) == '0));

  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_vc_en != '0) |=> ((wr_vc_en & $past(wr_vc_en)) == '0));

  a_r5_not_arrival_port: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_vc_en != '0) |-> (wr_port != port_q));

  a_r8_stall_blocks_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    stall |-> (wr_vc_en == '0));

  a_r8_stall_holds_mask: assert property (@(posedge clk) disable iff (!rst_i_n)
    stall |=> $stable(pend_q));

  a_r2_closed_after_take: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && in_ready && (in_mask != '0)) |=> !in_ready);

  a_r10_reopen: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((wr_vc_en != '0) && ($countones(pend_q) == 1)) |=> in_ready);

endmodule

// File: tb/mcast_repl_alloc_bench.sv
module mcast_repl_alloc_bench;
  localparam int NP = 5, NV = 4, ND = 8, FW = 32;
  localparam int NCH = NP * NV;

  typedef struct packed {
    logic [2:0]  port;
    logic [7:0]  mask;
    logic [19:0] busy;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{port: 3'd0, mask: 8'h05, busy: 20'h00000},
    '{port: 3'd2, mask: 8'hFF, busy: 20'h00000},
    '{port: 3'd1, mask: 8'h3C, busy: 20'hF00F0},
    '{port: 3'd3, mask: 8'h81, busy: 20'h5A3C6},
    '{port: 3'd0, mask: 8'h0E, busy: 20'hE7BFF},
    '{port: 3'd4, mask: 8'h00, busy: 20'h12345}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [2:0]     in_port;
  logic [ND-1:0]  in_mask;
  logic [FW-1:0]  in_flit;
  logic [NCH-1:0] vc_busy;
  logic [NCH-1:0] wr_vc_en;
  logic [2:0]     wr_port;
  logic [1:0]     wr_vc;
  logic [2:0]     wr_dest;
  logic [FW-1:0]  wr_flit;
  logic           stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mcast_repl_alloc u_mcast_repl_alloc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_port(in_port), .in_mask(in_mask), .in_flit(in_flit), .vc_busy(vc_busy),
    .wr_vc_en(wr_vc_en), .wr_port(wr_port), .wr_vc(wr_vc), .wr_dest(wr_dest),
    .wr_flit(wr_flit), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // least-loaded eligible port, ties low; lowest free channel there
  function automatic void model_pick(input logic [NCH-1:0] occ, input logic [2:0] inp,
                                     output bit ok, output int mp, output int mv);
    int best = 0;
    ok = 1'b0; mp = 0; mv = 0;
    for (int p = 0; p < NP; p++) begin
      int c = 0;
      for (int v = 0; v < NV; v++) if (!occ[p*NV+v]) c++;
      if (p != int'(inp) && c > best) begin best = c; mp = p; ok = 1'b1; end
    end
    for (int v = NV - 1; v >= 0; v--) if (!occ[mp*NV+v]) mv = v;
  endfunction

  task automatic run_vec(input vec_t vv, input logic [FW-1:0] fl);
    logic [NCH-1:0] occ;
    logic [ND-1:0]  rem;
    bit ok; int mp; int mv; int md;
    occ = vv.busy;
    rem = vv.mask;
    @(negedge clk);
    vc_busy = occ; in_port = vv.port; in_mask = vv.mask; in_flit = fl; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R2 ready before offer", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (vv.mask == '0)
      chk(in_ready && wr_vc_en == '0, "R2 empty mask no write", 64'(wr_vc_en), 64'd0);
    while (rem != '0) begin
      md = 0;
      for (int d = ND - 1; d >= 0; d--) if (rem[d]) md = d;
      model_pick(occ, vv.port, ok, mp, mv);
      chk(ok, "R8 vector needs free channel", 64'(ok), 64'd1);
      chk(wr_vc_en == (NCH'(1) << (mp*NV+mv)), "R4 R5 R6 R7 write enable",
          64'(wr_vc_en), 64'(NCH'(1) << (mp*NV+mv)));
      chk(wr_port == 3'(mp) && wr_vc == 2'(mv), "R6 R7 port/vc",
          {wr_port, wr_vc}, {3'(mp), 2'(mv)});
      chk(wr_dest == 3'(md), "R3 ascending destination", 64'(wr_dest), 64'(md));
      chk(wr_flit == fl, "R9 payload", 64'(wr_flit), 64'(fl));
      chk(!in_ready && !stall, "R2 closed while copying", 64'(in_ready), 64'd0);
      occ[mp*NV+mv] = 1'b1;
      rem[md] = 1'b0;
      @(posedge clk);
      @(negedge clk);
      vc_busy = occ;
    end
    chk(in_ready == 1'b1, "R10 ready after last copy", 64'(in_ready), 64'd1);
    chk(wr_vc_en == '0, "R3 no extra copy", 64'(wr_vc_en), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_port = '0; in_mask = '0; in_flit = '0; vc_busy = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", 64'(in_ready), 64'd1);
    chk(stall == 1'b0, "R1 reset stall", 64'(stall), 64'd0);
    chk(wr_vc_en == '0, "R1 reset no write", 64'(wr_vc_en), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 32'hC0DE_0000 + 32'(i));

    // R8: every eligible port full, arrival port empty -> stall, flit held
    @(negedge clk);
    vc_busy = 20'hFFFF0; in_port = 3'd0; in_mask = 8'h02; in_flit = 32'h5717_0001; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(stall == 1'b1, "R8 stall raised", 64'(stall), 64'd1);
    chk(wr_vc_en == '0, "R8 R5 no write while stalled", 64'(wr_vc_en), 64'd0);
    // R2: offer during stall must be ignored
    in_valid = 1'b1; in_mask = 8'hFF; in_flit = 32'hBAD0_BAD0; in_port = 3'd4;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(stall == 1'b1 && !in_ready, "R8 still stalled", 64'(stall), 64'd1);
    vc_busy = 20'hFBFF0;  // frees port 3 channel 2
    #1;
    chk(wr_vc_en == (NCH'(1) << 14), "R8 resumes on free channel", 64'(wr_vc_en), 64'(NCH'(1) << 14));
    chk(wr_dest == 3'd1, "R2 held destination kept", 64'(wr_dest), 64'd1);
    chk(wr_flit == 32'h5717_0001, "R2 R9 held payload kept", 64'(wr_flit), 64'h57170001);
    @(posedge clk);
    @(negedge clk);
    vc_busy = 20'hFFFF0;
    chk(in_ready && !stall && wr_vc_en == '0, "R2 R10 ignored offer left nothing",
        64'(wr_vc_en), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule